// File: doc/BRIEF.md
# Coherent Conversion Result Register

This block keeps the most recent conversion result and shows it to a processor as two bytes on a byte-wide read port. The high byte and the low byte are always views of one stored value. A justify select chooses between two layouts. In the right-justified layout, the low byte holds the lower eight result bits. In the left-justified layout, the high byte holds the top eight result bits, so software that needs only eight bits of precision can read that byte alone.

Software reads a full-precision result as a pair: the low byte first, then the high byte. A low-byte read sets an internal hold. While the hold is set, a newly arriving result is thrown away and both bytes keep the value that software has half read. The completion flag still rises for the thrown-away result. A sticky lost indication records that the discard happened. A high-byte read releases the hold, clears the completion flag and clears the lost indication.

Top module: `adc_result_latch`

## Requirements
- R1: After reset both bytes read 0, the completion flag and the lost indication are 0, and there is no hold.
- R2: With just_left at 0, byte_hi equals the stored value divided by 256 (its upper six bits are 0), and byte_lo equals the stored value modulo 256.
- R3: With just_left at 1, byte_hi equals the stored value divided by 4, and byte_lo equals the stored value modulo 4 multiplied by 64 (its lower six bits are 0).
- R4: just_left changes only the byte view of the stored value. The view follows it in the same cycle, and toggling it leaves the stored value untouched.
- R5: A res_wr pulse with no hold set stores res_data. The bytes show the new value and done_flag is 1 from the next cycle.
- R6: An rd_lo pulse sets the hold from the next cycle. A write in the same cycle as the rd_lo pulse is still accepted.
- R7: An rd_hi pulse clears the hold. A write in the cycle after it is accepted. When rd_lo and rd_hi arrive together, no hold is left.
- R8: A write that arrives while the hold is set is discarded. Both bytes stay unchanged, yet done_flag and lost_flag are 1 from the next cycle.
- R9: An rd_hi pulse clears lost_flag, unless a write is discarded in that same cycle, in which case lost_flag is 1.
- R10: An rd_hi pulse clears done_flag, unless res_wr is high in that same cycle, in which case done_flag is 1.
- R11: An rd_hi pulse with no hold set leaves the stored value and the byte views unchanged.
- R12: A write that arrives together with an rd_hi pulse while the hold is set is discarded. A write in the following cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_data | input | 10 | New conversion result |
| res_wr | input | 1 | One-cycle strobe that offers res_data |
| just_left | input | 1 | 1 selects the left-justified byte view |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| byte_hi | output | 8 | High byte of the selected view |
| byte_lo | output | 8 | Low byte of the selected view |
| done_flag | output | 1 | Completion flag, set by every write strobe |
| lost_flag | output | 1 | Sticky record of a discarded result |

## Verification
The hazardous overlaps are a result strobe meeting a read strobe in the same cycle. A write together with a low-byte read while no hold is set must still be accepted. A write together with a high-byte read while the hold is set must still be discarded, and in that case the flags must settle with "set" winning over "clear". The bench drives these pairs on the same clock edge. It then judges them through the bytes: it shows which value is stored and whether a follow-up write is accepted. It also judges them through the completion and lost flags, sampled one cycle later. A full sweep of every result value under both layouts checks the byte arithmetic.

// File: rtl/adcres_pkg.sv
package adcres_pkg;
  localparam int DEF_RES_W  = 10;
  localparam int DEF_BYTE_W = 8;
  localparam int WORD_MAX_W = 32;

  typedef enum logic { JUST_RIGHT = 1'b0, JUST_LEFT = 1'b1 } justify_e;

  // Place the stored result in a two-byte word; left layout shifts by pad bits.
  function automatic logic [WORD_MAX_W-1:0] justify_word(
      input logic [WORD_MAX_W-1:0] value,
      input int                    pad,
      input justify_e              mode);
    return (mode == JUST_LEFT) ? (value << pad) : value;
  endfunction

  // Hold state after one cycle of read strobes: the high read closes the pair.
  function automatic logic next_hold(input logic hold, input logic lo, input logic hi);
    return hi ? 1'b0 : (lo ? 1'b1 : hold);
  endfunction

  // Sticky bit with priority of set over clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/adcres_lock.sv
module adcres_lock
  import adcres_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic res_wr,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic hold_on,
  output logic lost_q,
  output logic wr_accept,
  output logic wr_drop
);
  logic hold_q;

  assign hold_on   = hold_q;
  assign wr_accept = res_wr & ~hold_q;
  assign wr_drop   = res_wr &  hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      hold_q <= next_hold(hold_q, rd_lo, rd_hi);
      lost_q <= sticky_next(lost_q, wr_drop, rd_hi);
    end
  end
endmodule

// File: rtl/adcres_store.sv
module adcres_store
  import adcres_pkg::*;
#(
  parameter int RES_W = DEF_RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_accept,
  input  logic             res_wr,
  input  logic             rd_hi,
  input  logic [RES_W-1:0] res_data,
  output logic [RES_W-1:0] stored_q,
  output logic             done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (wr_accept) stored_q <= res_data;
      done_q <= sticky_next(done_q, res_wr, rd_hi);
    end
  end
endmodule

// File: rtl/adcres_view.sv
module adcres_view
  import adcres_pkg::*;
#(
  parameter int RES_W  = DEF_RES_W,
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic [RES_W-1:0]  stored,
  input  logic              just_left,
  output logic [BYTE_W-1:0] view_hi,
  output logic [BYTE_W-1:0] view_lo
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD    = WORD_W - RES_W;

  logic [WORD_MAX_W-1:0] word;
  justify_e              mode;

  always_comb begin
    mode    = just_left ? JUST_LEFT : JUST_RIGHT;
    word    = justify_word(WORD_MAX_W'(stored), PAD, mode);
    view_hi = word[WORD_W-1:BYTE_W];
    view_lo = word[BYTE_W-1:0];
  end
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch
  import adcres_pkg::*;
#(
  parameter int RES_W  = DEF_RES_W,
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RES_W-1:0]  res_data,
  input  logic              res_wr,
  input  logic              just_left,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] byte_hi,
  output logic [BYTE_W-1:0] byte_lo,
  output logic              done_flag,
  output logic              lost_flag
);
  logic             hold_on;
  logic             wr_accept;
  logic             wr_drop;
  logic [RES_W-1:0] stored_q;

  adcres_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_wr   (res_wr),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .hold_on  (hold_on),
    .lost_q   (lost_flag),
    .wr_accept(wr_accept),
    .wr_drop  (wr_drop)
  );

  adcres_store #(.RES_W(RES_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_accept(wr_accept),
    .res_wr   (res_wr),
    .rd_hi    (rd_hi),
    .res_data (res_data),
    .stored_q (stored_q),
    .done_q   (done_flag)
  );

  adcres_view #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_view (
    .stored   (stored_q),
    .just_left(just_left),
    .view_hi  (byte_hi),
    .view_lo  (byte_lo)
  );
endmodule

// File: rtl/adcres_chk.sv
module adcres_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RES_W-1:0]  res_data,
  input logic              res_wr,
  input logic              just_left,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic [BYTE_W-1:0] byte_hi,
  input logic [BYTE_W-1:0] byte_lo,
  input logic              done_flag,
  input logic              lost_flag,
  input logic              hold_on,
  input logic              wr_accept,
  input logic              wr_drop,
  input logic [RES_W-1:0]  stored_q
);
  localparam int PAD = 2 * BYTE_W - RES_W;
  localparam logic [BYTE_W-1:0] LO_PAD_MASK = BYTE_W'((1 << PAD) - 1);

  // R2
  right_hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !just_left |-> ((byte_hi >> (RES_W - BYTE_W)) == '0));

  // R3
  left_lo_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    just_left |-> ((byte_lo & LO_PAD_MASK) == '0));

  // R5
  accept_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (stored_q == $past(res_data)) && done_flag);

  // R8
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> $stable(stored_q) && done_flag && lost_flag);

  // R6
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi) |=> hold_on);

  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !hold_on);

  // R9
  lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !wr_drop) |=> !lost_flag);

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !res_wr) |=> !done_flag);

  // R11
  idle_hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !hold_on && !res_wr) |=> $stable(stored_q));

  // R12
  drop_with_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && hold_on && res_wr) |-> wr_drop);
endmodule

bind adc_result_latch adcres_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .res_data (res_data),
  .res_wr   (res_wr),
  .just_left(just_left),
  .rd_lo    (rd_lo),
  .rd_hi    (rd_hi),
  .byte_hi  (byte_hi),
  .byte_lo  (byte_lo),
  .done_flag(done_flag),
  .lost_flag(lost_flag),
  .hold_on  (hold_on),
  .wr_accept(wr_accept),
  .wr_drop  (wr_drop),
  .stored_q (stored_q)
);

// File: tb/adc_result_latch_test.sv
`timescale 1ns/1ps
module adc_result_latch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] res_data = '0;
  logic       res_wr = 1'b0;
  logic       just_left = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] byte_hi;
  logic [7:0] byte_lo;
  logic       done_flag;
  logic       lost_flag;

  int total = 0;
  int bad   = 0;

  int  m_val  = 0;
  bit  m_hold = 0;
  bit  m_done = 0;
  bit  m_lost = 0;

  always #2.5 clk = ~clk;

  adc_result_latch uut (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_wr(res_wr),
    .just_left(just_left), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .byte_hi(byte_hi), .byte_lo(byte_lo),
    .done_flag(done_flag), .lost_flag(lost_flag)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic check_view(input string tag);
    int eh, el;
    if (just_left) begin
      eh = m_val / 4;
      el = (m_val % 4) * 64;
    end else begin
      eh = m_val / 256;
      el = m_val % 256;
    end
    check({tag, " byte_hi"}, int'(byte_hi), eh);
    check({tag, " byte_lo"}, int'(byte_lo), el);
  endtask

  task automatic check_flags(input string tag);
    check({tag, " done_flag"}, int'(done_flag), int'(m_done));
    check({tag, " lost_flag"}, int'(lost_flag), int'(m_lost));
  endtask

  // One clock of stimulus; the model follows the written requirements.
  task automatic step(input bit wr, input int d, input bit lo, input bit hi);
    bit drop;
    @(negedge clk);
    res_wr = wr; res_data = 10'(d); rd_lo = lo; rd_hi = hi;
    drop = wr && m_hold;
    if (wr && !m_hold) m_val = d;
    if (wr) m_done = 1;
    else if (hi) m_done = 0;
    if (drop) m_lost = 1;
    else if (hi) m_lost = 0;
    if (hi) m_hold = 0;
    else if (lo) m_hold = 1;
    @(posedge clk);
    #1;
    res_wr = 0; rd_lo = 0; rd_hi = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check_view("R1 reset");
    check_flags("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R5: sweep every value, both layouts
    for (int v = 0; v < 1024; v++) begin
      just_left = 1'b0;
      step(1, v, 0, 0);
      check_view("R2 R5 right");
      #1 just_left = 1'b1;
      #1 check_view("R3 left");
      just_left = 1'b0;
    end
    check_flags("R5 done after write");

    // R10 high read clears done
    step(0, 0, 0, 1);
    check_flags("R10 done clear");

    // R4 toggling layout leaves stored value
    step(1, 10'h2A7, 0, 0);
    for (int k = 0; k < 4; k++) begin
      just_left = k[0];
      #1 check_view("R4 toggle");
    end
    just_left = 1'b0;

    // R11 high read with no hold
    step(0, 0, 0, 1);
    check_view("R11 idle hi read");
    step(1, 10'h155, 0, 0);
    check_view("R11 write after idle hi");

    // R6 R8 hold and discard
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    check_flags("R10 clear before hold test");
    step(0, 0, 1, 0);
    step(1, 10'h3C3, 0, 0);
    check_view("R8 dropped keeps bytes");
    check_flags("R8 dropped flags");
    step(1, 10'h001, 0, 0);
    check_view("R6 still held");

    // R7 R9 release
    step(0, 0, 0, 1);
    check_flags("R9 lost clear");
    step(1, 10'h2E1, 0, 0);
    check_view("R7 accepted after release");

    // R6 write with lo read while unlocked is accepted, then held
    step(1, 10'h0F0, 1, 0);
    check_view("R6 same-cycle lo accept");
    step(1, 10'h3FF, 0, 0);
    check_view("R6 held after lo");

    // R12 write with hi read while held: dropped, lost kept set
    step(1, 10'h123, 0, 1);
    check_view("R12 drop with hi");
    check_flags("R12 R9 set wins");
    step(1, 10'h321, 0, 0);
    check_view("R12 accept next");
    check_flags("R10 done with write");

    // R7 lo and hi together leave no hold
    step(0, 0, 1, 1);
    step(1, 10'h0AB, 0, 0);
    check_view("R7 pair leaves no hold");
    just_left = 1'b1;
    #1 check_view("R3 left final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule